// File: doc/BRIEF.md
# Blanking-Interval Side-Channel Scheduler

This block sits beside the parallel video port of one end of a point-to-point video link. It follows the line and frame timing (HSYNC, VSYNC, DATAEN) to find the start of vertical blanking. There it opens a window two lines long. Inside that window it lends the link to a low-rate auxiliary byte channel, so that auxiliary bytes travel in both directions once per frame and take no active-video bandwidth.

Inside the window the local end transmits first. It sends a length symbol and then up to a fixed per-frame budget of queued bytes. After that it receives the far end's length symbol and payload into a receive queue. Local software side logic writes bytes into a transmit queue and drains the receive queue, both through valid/ready streams. A line coder on the other side exchanges symbols with the block through a transmit handshake and a receive handshake. After each window, the byte counts of the last window, a frame counter and a sticky protocol-error flag are available as plain outputs.

Back-pressure rules:
- A stream item moves on a rising clock edge where both valid and ready are high.
- The block holds `lc_tx_data` and `rx_rd_data` stable while their valid is high and ready is low.
- The block never waits on `tx_wr_valid` or `lc_rx_valid`.

Both queues have a depth that is a power of two.

Top module: `sc_blank_sched`

## Requirements
- R1: HSYNC, VSYNC and DATAEN are all active high. A "blank line" is a line between two HSYNC rising edges during which DATAEN stays low. The window opens on the first HSYNC rising edge that ends a blank line which follows a line containing DATAEN. `window_open` is high from the clock after that edge up to and including the clock of the second HSYNC rising edge after it. It is low from the next clock on.
- R2: Each window starts with exactly one symbol on `lc_tx_data`. That symbol is the payload length L, equal to the queued byte count at window opening capped at 224. The L oldest queued bytes then follow in write order. `lc_tx_valid` is never high while `window_open` is low.
- R3: No more than 224 payload bytes are sent in one window. Bytes beyond that stay queued and go out first in the next window.
- R4: After the local payload (or after a length of 0), the block accepts one far-end length symbol N (0 to 224). It then accepts N payload bytes and delivers them on `rx_rd_data` in arrival order. `lc_rx_ready` is never high while `window_open` is low.
- R5: A received length symbol above 224 sets `proto_err`, which stays high until reset. Every further received symbol in that window is accepted and dropped, and none reaches the receive queue.
- R6: While `sc_off` is high, no window opens and no symbol is exchanged. The status outputs do not change, and queued transmit bytes are kept. A window that is already open is allowed to finish.
- R7: VSYNC high closes an open window on the next clock and prevents a window from opening, so auxiliary traffic stays inside the front porch.
- R8: On the clock where a window closes, `sent_cnt` and `rcvd_cnt` take the number of payload bytes sent and received in that window, and `frame_cnt` increments by one.
- R9: `tx_wr_ready` is high whenever the transmit queue is not full. `rx_rd_data` and `lc_tx_data` stay stable while their valid is high and ready is low.
- R10: After reset: `window_open` is low; `sent_cnt`, `rcvd_cnt` and `frame_cnt` are zero; `proto_err` and `rx_rd_valid` are low; `tx_wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Line sync, active high |
| vsync | input | 1 | Frame sync, active high |
| de | input | 1 | Active-video qualifier, active high |
| sc_off | input | 1 | High disables the side channel |
| tx_wr_valid | input | 1 | Transmit queue write valid |
| tx_wr_data | input | 8 | Transmit queue write byte |
| tx_wr_ready | output | 1 | Transmit queue not full |
| rx_rd_valid | output | 1 | Receive queue has a byte |
| rx_rd_data | output | 8 | Oldest received byte |
| rx_rd_ready | input | 1 | Consumer takes the byte |
| lc_tx_valid | output | 1 | Symbol offered to the line coder |
| lc_tx_data | output | 8 | Symbol toward the line coder |
| lc_tx_ready | input | 1 | Line coder takes the symbol |
| lc_rx_valid | input | 1 | Symbol from the line coder |
| lc_rx_data | input | 8 | Received symbol |
| lc_rx_ready | output | 1 | Block takes the received symbol |
| window_open | output | 1 | Side-channel window active |
| sent_cnt | output | 8 | Payload bytes sent in the last window |
| rcvd_cnt | output | 8 | Payload bytes received in the last window |
| frame_cnt | output | 16 | Number of windows closed |
| proto_err | output | 1 | Sticky oversize-length flag |

## Verification
The state that matters most is the window line counter and the memory of having seen active video. If either is wrong, `window_open` rises or falls one line early or late, and that shows within one clock of the HSYNC edge concerned. A wrong transfer state or remaining-byte count shows at once in the order of symbols on the transmit handshake, or as a byte missing from or added to the receive stream. It then shows again in `sent_cnt` and `rcvd_cnt` on the clock the window closes. A budget cap that is off by one shows as a wrong length symbol, and in the next frame as a shifted byte.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    SC_IDLE,
    SC_TX_LEN,
    SC_TX_DAT,
    SC_RX_LEN,
    SC_RX_DAT,
    SC_RX_DROP,
    SC_HOLD
  } sc_state_e;
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL_C = DEPTH[CW-1:0];

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != FULL_C);
  assign do_pop  = pop && (count != '0);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sc_vbi_detect.sv
module sc_vbi_detect #(
  parameter int WIN_LINES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic de,
  input  logic en,
  output logic win,
  output logic open_now,
  output logic close_now
);
  localparam int LW = (WIN_LINES > 1) ? $clog2(WIN_LINES) : 1;
  localparam logic [LW-1:0] LAST_C = LW'(WIN_LINES - 1);

  logic          hs_q, hs_rise;
  logic          de_line;     // DATAEN seen in the current line
  logic          seen_act;    // active video seen since the last blank edge
  logic          blank_edge;
  logic [LW-1:0] ln;

  assign hs_rise    = hsync && !hs_q;
  assign blank_edge = hs_rise && seen_act && !de_line;
  assign open_now   = blank_edge && !win && en && !vsync;
  assign close_now  = win && (vsync || (hs_rise && (ln == LAST_C)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q     <= 1'b0;
      de_line  <= 1'b0;
      seen_act <= 1'b0;
      win      <= 1'b0;
      ln       <= '0;
    end else begin
      hs_q <= hsync;
      if (hs_rise)  de_line <= de;
      else if (de)  de_line <= 1'b1;
      if (blank_edge) seen_act <= 1'b0;
      else if (de)    seen_act <= 1'b1;
      if (close_now) begin
        win <= 1'b0;
      end else if (open_now) begin
        win <= 1'b1;
        ln  <= '0;
      end else if (win && hs_rise) begin
        ln <= ln + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_xfer_fsm.sv
module sc_xfer_fsm
  import sc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BUDGET = 224,
  parameter int CW     = 9,
  parameter int FW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_now,
  input  logic          close_now,
  input  logic [CW-1:0] tx_fill,
  input  logic [DW-1:0] tx_head,
  output logic          tx_pop,
  output logic          lc_tx_valid,
  output logic [DW-1:0] lc_tx_data,
  input  logic          lc_tx_ready,
  input  logic          lc_rx_valid,
  input  logic [DW-1:0] lc_rx_data,
  output logic          lc_rx_ready,
  output logic          rx_push,
  input  logic          rx_space,
  output logic [DW-1:0] sent_cnt,
  output logic [DW-1:0] rcvd_cnt,
  output logic [FW-1:0] frame_cnt,
  output logic          proto_err
);
  localparam logic [CW-1:0] BUD_CW = BUDGET[CW-1:0];
  localparam logic [DW-1:0] BUD_DW = BUDGET[DW-1:0];

  sc_state_e     st, nxt;
  logic [DW-1:0] len_sel, len_q, tx_left, rx_left, tx_run, rx_run;
  logic          err_set, rx_take;

  assign len_sel = (tx_fill > BUD_CW) ? BUD_DW : tx_fill[DW-1:0];
  assign rx_take = lc_rx_valid && lc_rx_ready;

  always_comb begin
    nxt         = st;
    lc_tx_valid = 1'b0;
    lc_tx_data  = tx_head;
    tx_pop      = 1'b0;
    lc_rx_ready = 1'b0;
    rx_push     = 1'b0;
    err_set     = 1'b0;
    case (st)
      SC_TX_LEN: begin
        lc_tx_valid = 1'b1;
        lc_tx_data  = len_q;
        if (lc_tx_ready) nxt = (len_q == '0) ? SC_RX_LEN : SC_TX_DAT;
      end
      SC_TX_DAT: begin
        lc_tx_valid = (tx_fill != '0);
        if (lc_tx_valid && lc_tx_ready) begin
          tx_pop = 1'b1;
          if (tx_left == DW'(1)) nxt = SC_RX_LEN;
        end
      end
      SC_RX_LEN: begin
        lc_rx_ready = 1'b1;
        if (lc_rx_valid) begin
          if (lc_rx_data > BUD_DW) begin
            err_set = 1'b1;
            nxt     = SC_RX_DROP;
          end else if (lc_rx_data == '0) begin
            nxt = SC_HOLD;
          end else begin
            nxt = SC_RX_DAT;
          end
        end
      end
      SC_RX_DAT: begin
        lc_rx_ready = rx_space;
        if (rx_take) begin
          rx_push = 1'b1;
          if (rx_left == DW'(1)) nxt = SC_HOLD;
        end
      end
      SC_RX_DROP: lc_rx_ready = 1'b1;
      default: ;
    endcase
    if (close_now)     nxt = SC_IDLE;
    else if (open_now) nxt = SC_TX_LEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SC_IDLE;
      len_q     <= '0;
      tx_left   <= '0;
      rx_left   <= '0;
      tx_run    <= '0;
      rx_run    <= '0;
      sent_cnt  <= '0;
      rcvd_cnt  <= '0;
      frame_cnt <= '0;
      proto_err <= 1'b0;
    end else begin
      st <= nxt;
      if (err_set) proto_err <= 1'b1;
      if (open_now) begin
        len_q   <= len_sel;
        tx_left <= len_sel;
        tx_run  <= '0;
        rx_run  <= '0;
      end else begin
        if (tx_pop) begin
          tx_left <= tx_left - 1'b1;
          tx_run  <= tx_run + 1'b1;
        end
        if (st == SC_RX_LEN && rx_take) rx_left <= lc_rx_data;
        if (rx_push) begin
          rx_left <= rx_left - 1'b1;
          rx_run  <= rx_run + 1'b1;
        end
      end
      if (close_now) begin
        sent_cnt  <= tx_run + DW'(tx_pop);
        rcvd_cnt  <= rx_run + DW'(rx_push);
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_blank_sched.sv
module sc_blank_sched #(
  parameter int DW        = 8,
  parameter int BUDGET    = 224,
  parameter int DEPTH     = 256,
  parameter int WIN_LINES = 2,
  parameter int FW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          de,
  input  logic          sc_off,
  input  logic          tx_wr_valid,
  input  logic [DW-1:0] tx_wr_data,
  output logic          tx_wr_ready,
  output logic          rx_rd_valid,
  output logic [DW-1:0] rx_rd_data,
  input  logic          rx_rd_ready,
  output logic          lc_tx_valid,
  output logic [DW-1:0] lc_tx_data,
  input  logic          lc_tx_ready,
  input  logic          lc_rx_valid,
  input  logic [DW-1:0] lc_rx_data,
  output logic          lc_rx_ready,
  output logic          window_open,
  output logic [DW-1:0] sent_cnt,
  output logic [DW-1:0] rcvd_cnt,
  output logic [FW-1:0] frame_cnt,
  output logic          proto_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = DEPTH[CW-1:0];

  logic [CW-1:0] tx_fill, rx_fill;
  logic [DW-1:0] tx_head;
  logic          tx_pop, rx_push, rx_space, open_now, close_now;

  assign tx_wr_ready = (tx_fill != FULL_C);
  assign rx_space    = (rx_fill != FULL_C);
  assign rx_rd_valid = (rx_fill != '0);

  sc_vbi_detect #(.WIN_LINES(WIN_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
    .en(!sc_off), .win(window_open), .open_now(open_now), .close_now(close_now)
  );

  sc_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr_valid && tx_wr_ready), .wdata(tx_wr_data),
    .pop(tx_pop), .rdata(tx_head), .count(tx_fill)
  );

  sc_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(lc_rx_data),
    .pop(rx_rd_valid && rx_rd_ready), .rdata(rx_rd_data), .count(rx_fill)
  );

  sc_xfer_fsm #(.DW(DW), .BUDGET(BUDGET), .CW(CW), .FW(FW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .open_now(open_now), .close_now(close_now),
    .tx_fill(tx_fill), .tx_head(tx_head), .tx_pop(tx_pop),
    .lc_tx_valid(lc_tx_valid), .lc_tx_data(lc_tx_data), .lc_tx_ready(lc_tx_ready),
    .lc_rx_valid(lc_rx_valid), .lc_rx_data(lc_rx_data), .lc_rx_ready(lc_rx_ready),
    .rx_push(rx_push), .rx_space(rx_space),
    .sent_cnt(sent_cnt), .rcvd_cnt(rcvd_cnt), .frame_cnt(frame_cnt), .proto_err(proto_err)
  );
endmodule

// File: rtl/sc_blank_sched_chk.sv
module sc_blank_sched_chk #(
  parameter int DW     = 8,
  parameter int BUDGET = 224,
  parameter int FW     = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic          sc_off,
  input logic          rx_rd_valid,
  input logic [DW-1:0] rx_rd_data,
  input logic          rx_rd_ready,
  input logic          lc_tx_valid,
  input logic          lc_rx_ready,
  input logic          window_open,
  input logic [DW-1:0] sent_cnt,
  input logic [FW-1:0] frame_cnt,
  input logic          proto_err
);
  a_r2_tx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    lc_tx_valid |-> window_open);

  a_r3_budget: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sent_cnt) <= BUDGET);

  a_r4_rx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    lc_rx_ready |-> window_open);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  a_r6_off_no_open: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_off && !window_open) |=> !window_open);

  a_r7_vsync_close: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && window_open) |=> !window_open);

  a_r8_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_open) |-> (frame_cnt == FW'($past(frame_cnt) + 1'b1)));

  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_valid && !rx_rd_ready) |=> (rx_rd_valid && $stable(rx_rd_data)));
endmodule

bind sc_blank_sched sc_blank_sched_chk #(.DW(DW), .BUDGET(BUDGET), .FW(FW)) i_chk (.*);

// File: tb/test_sc_blank_sched.sv
`timescale 1ns/1ps
module test_sc_blank_sched;
  localparam int LINE = 400;
  localparam int NLN  = 11;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       hsync = 0, vsync = 0, de = 0, sc_off = 0;
  logic       tx_wr_valid = 0, rx_rd_ready = 0, lc_tx_ready = 0, lc_rx_valid = 0;
  logic [7:0] tx_wr_data = 0, lc_rx_data = 0;
  logic       tx_wr_ready, rx_rd_valid, lc_tx_valid, lc_rx_ready, window_open, proto_err;
  logic [7:0] rx_rd_data, lc_tx_data, sent_cnt, rcvd_cnt;
  logic [15:0] frame_cnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit vid_done = 0, summary_done = 0;
  logic [7:0] model_q[$], exp_tx[$], exp_rx[$], rem_q[$];

  always #2.5 clk = ~clk;

  sc_blank_sched i_sc_blank_sched (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // back-pressure patterns, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    lc_tx_ready <= (cyc % 4) != 1;
    rx_rd_ready <= (cyc % 3) != 0;
  end

  // monitors: a handshake seen here completes on the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && lc_tx_valid && lc_tx_ready) begin
      if (exp_tx.size() == 0) chk("R2 unexpected tx symbol", int'(lc_tx_data), -1);
      else chk("R2 tx symbol", int'(lc_tx_data), int'(exp_tx.pop_front()));
    end
    if (rst_n && rx_rd_valid && rx_rd_ready) begin
      if (exp_rx.size() == 0) chk("R4 unexpected rx byte", int'(rx_rd_data), -1);
      else chk("R4 rx byte", int'(rx_rd_data), int'(exp_rx.pop_front()));
    end
  end

  task automatic push_tx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(base + 3 * i);
      @(negedge clk);
      tx_wr_valid = 1; tx_wr_data = b;
      #1;
      while (!tx_wr_ready) begin @(negedge clk); #1; end
      model_q.push_back(b);
    end
    @(negedge clk);
    tx_wr_valid = 0;
  endtask

  task automatic remote_send();
    while (rem_q.size() > 0 && !vid_done) begin
      @(negedge clk);
      lc_rx_valid = 1; lc_rx_data = rem_q[0];
      #1;
      if (lc_rx_ready) void'(rem_q.pop_front());
    end
    @(negedge clk);
    lc_rx_valid = 0;
  endtask

  task automatic video(input bit en, input int vs_line, input int vs_cyc);
    int vs0;
    vs0 = vs_line * LINE + vs_cyc;
    for (int ln = 0; ln < NLN; ln++) begin
      for (int c = 0; c < LINE; c++) begin
        int a;
        a = ln * LINE + c;
        @(negedge clk);
        hsync = (c < 8);
        de    = (ln < 4) && (c >= 20) && (c < 84);
        vsync = (a >= vs0) && (a < vs0 + 2 * LINE);
        if (c == 1 && ln >= 4 && ln <= 7) begin
          int e;
          e = (en && (ln == 5 || ln == 6) && (a < vs0)) ? 1 : 0;
          #1;
          if (!en) chk("R6 window stays closed", int'(window_open), 0);
          else if (ln == 6 && vs0 < a) chk("R7 vsync closed window", int'(window_open), e);
          else chk("R1 window line timing", int'(window_open), e);
        end
      end
    end
    vid_done = 1;
  endtask

  task automatic frame(input bit en, input int vs_line, input int vs_cyc);
    if (en) begin
      int l;
      l = (model_q.size() > 224) ? 224 : model_q.size();
      exp_tx.push_back(8'(l));
      for (int i = 0; i < l; i++) exp_tx.push_back(model_q.pop_front());
    end
    vid_done = 0;
    fork
      video(en, vs_line, vs_cyc);
      remote_send();
    join
    chk("R2 all expected tx symbols seen", exp_tx.size(), 0);
    chk("R4 all expected rx bytes seen", exp_rx.size(), 0);
  endtask

  task automatic status(input string req, input int s, input int r, input int f, input int e);
    chk({req, " sent_cnt"}, int'(sent_cnt), s);
    chk({req, " rcvd_cnt"}, int'(rcvd_cnt), r);
    chk({req, " frame_cnt"}, int'(frame_cnt), f);
    chk({req, " proto_err"}, int'(proto_err), e);
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R10 reset state
    chk("R10 window_open", int'(window_open), 0);
    chk("R10 rx_rd_valid", int'(rx_rd_valid), 0);
    chk("R10 tx_wr_ready", int'(tx_wr_ready), 1);
    chk("R10 lc_tx_valid", int'(lc_tx_valid), 0);
    status("R10", 0, 0, 0, 0);

    // frame 1: short exchange both ways
    push_tx(5, 8'h10);
    rem_q = '{8'd3, 8'hA1, 8'hA2, 8'hA3};
    exp_rx = '{8'hA1, 8'hA2, 8'hA3};
    frame(1, 8, 0);
    status("R8 frame1", 5, 3, 1, 0);

    // frame 2: over-budget local queue, full far-end budget (R3)
    push_tx(230, 8'h40);
    chk("R9 queue accepted 230", model_q.size(), 230);
    rem_q = '{8'd224};
    for (int i = 0; i < 224; i++) begin
      rem_q.push_back(8'(i * 5 + 1));
      exp_rx.push_back(8'(i * 5 + 1));
    end
    frame(1, 8, 0);
    status("R3 frame2", 224, 224, 2, 0);

    // frame 3: channel disabled (R6)
    sc_off = 1;
    frame(0, 8, 0);
    status("R6 frame3", 224, 224, 2, 0);
    sc_off = 0;

    // frame 4: the 6 left-over bytes go out first (R3), far end sends nothing
    chk("R3 leftover in model", model_q.size(), 6);
    rem_q = '{8'd0};
    frame(1, 8, 0);
    status("R3 frame4", 6, 0, 3, 0);

    // frame 5: oversize far-end length (R5)
    rem_q = '{8'd250, 8'h01, 8'h02, 8'h03};
    frame(1, 8, 0);
    status("R5 frame5", 0, 0, 4, 1);
    chk("R5 nothing queued for reading", int'(rx_rd_valid), 0);

    // frame 6: VSYNC in the first window line cuts it short (R7)
    frame(1, 5, 50);
    status("R7 frame6", 0, 0, 5, 1);

    summary();
  end
endmodule